// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Registers

This block keeps one interrupt-enable register and one interrupt-status register for each of five localities. All five share one interrupt request line. The command engine and the locality arbiter report events. Each event names a target locality and one or more source bits. An event latches into that locality's status only for the sources that locality has enabled, and only while its global enable is set. Any latch raises the shared line.

Software reaches the registers through a simple write port and a combinational read port. Each port carries a locality number and a register select. Only the locality that is currently active may change its enable or status register. Status bits are cleared by writing 1 to them. The shared line goes low when a status write leaves the writing locality's status at zero. The state of the other localities does not affect this. The vector register returns a fixed value and ignores writes.

Top module: `irqlc_top`

## Requirements
- R1: After reset, every locality's enable register reads 0x0000_0008 (polarity = low level), every status register reads 0, and `irq` is 0.
- R2: A write to the enable register (select 0) from the active locality stores only bit 31 (global enable), bits 4:3 (polarity) and the supported source bits 0 (data available), 1 (status valid), 2 (locality changed) and 7 (command ready). All other bits read 0, so writing 0xFFFF_FFFF reads back 0x8000_009F.
- R3: Writes to enable or status (select 2) from a locality other than the active one, or while no locality is active (active number 5 to 7), leave every register and `irq` unchanged.
- R4: An event sets a status bit, and sets `irq` one cycle later, only if the target locality has both bit 31 and that source's enable bit set. Source bits that are not enabled, and all events while bit 31 is clear, have no effect.
- R5: An event whose locality number is 5 or higher is discarded.
- R6: A status write from the active locality clears each supported bit written as 1. Bits written as 0, and unsupported bit positions, have no effect.
- R7: When a status write leaves the writing locality's status at zero, `irq` goes to 0 on the next cycle, even if another locality still holds set bits. If the status is still nonzero after the write, `irq` stays 1.
- R8: The vector register (select 1) reads the `IRQ_VECTOR` parameter (default 5) in bits 3:0 and ignores writes. A read of a locality number of 5 or higher returns 0xFFFF_FFFF. Select 3 reads 0.
- R9: If an event latches in the same cycle as a status write that clears the same bit, the bit ends up set and `irq` is 1.
- R10: The polarity field can be read back after a write but does not change `irq`, which stays active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_loc | input | 3 | Active locality number; 5 to 7 means none |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | 3 | Locality of the write |
| wr_sel | input | 2 | Register select of the write: 0 enable, 1 vector, 2 status |
| wr_data | input | 32 | Write data |
| rd_loc | input | 3 | Locality of the read |
| rd_sel | input | 2 | Register select of the read |
| rd_data | output | 32 | Read data (combinational) |
| evt_valid | input | 1 | Event strobe |
| evt_loc | input | 3 | Target locality of the event |
| evt_src | input | 8 | Source bits of the event, same positions as the status register |
| irq | output | 1 | Shared interrupt request, registered, active-high |

## Verification
The bench gates events with each half of the enable condition in turn. A design that ORs the two enables instead of ANDing them would latch a bit with bit 31 clear. Another case leaves a second locality holding a pending bit while the active locality clears its own last bit. A design that lowers the line on the OR of all status registers would keep `irq` high there. Further tests write 1 to unsupported status bits, send an event to locality 5, and collide an event with a clear of the same bit. These expose a clear that is not masked, an event index that wraps onto a real locality, and a clear that overrides a new event.

// File: rtl/irqlc_pkg.sv
package irqlc_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_VECTOR = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    localparam int BIT_DATA_AVAIL = 0;
    localparam int BIT_STS_VALID  = 1;
    localparam int BIT_LOC_CHANGE = 2;
    localparam int BIT_CMD_READY  = 7;
    localparam int BIT_GLOBAL_EN  = 31;

    localparam logic [31:0] POLARITY_FIELD = 32'h0000_0018;
    localparam logic [31:0] ENABLE_RESET   = 32'h0000_0008;

    // Source bits that may latch into a status register.
    function automatic logic [31:0] source_mask(input bit with_valid);
        logic [31:0] m;
        m = '0;
        m[BIT_DATA_AVAIL] = 1'b1;
        m[BIT_LOC_CHANGE] = 1'b1;
        m[BIT_CMD_READY]  = 1'b1;
        m[BIT_STS_VALID]  = with_valid;
        return m;
    endfunction

    // Bits that an enable-register write keeps.
    function automatic logic [31:0] enable_keep(input bit with_valid);
        logic [31:0] m;
        m = source_mask(with_valid) | POLARITY_FIELD;
        m[BIT_GLOBAL_EN] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqlc_slot.sv
module irqlc_slot
    import irqlc_pkg::*;
#(
    parameter bit WITH_VALID = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_we,
    input  logic        sts_we,
    input  logic [31:0] wdata,
    input  logic        evt_hit,
    input  logic [7:0]  evt_src,
    output logic [31:0] en_q,
    output logic [31:0] sts_q,
    output logic        latch_any,
    output logic        zero_next
);
    localparam logic [31:0] SRC_M  = source_mask(WITH_VALID);
    localparam logic [31:0] KEEP_M = enable_keep(WITH_VALID);

    logic [31:0] latch_bits;
    logic [31:0] clr_bits;
    logic [31:0] sts_d;

    always_comb begin
        latch_bits = '0;
        if (evt_hit && en_q[BIT_GLOBAL_EN])
            latch_bits = {24'b0, evt_src} & en_q & SRC_M;
        clr_bits  = sts_we ? (wdata & SRC_M) : '0;
        sts_d     = (sts_q & ~clr_bits) | latch_bits;
        latch_any = |latch_bits;
        zero_next = (sts_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= ENABLE_RESET;
            sts_q <= '0;
        end else begin
            if (en_we)
                en_q <= wdata & KEEP_M;
            sts_q <= sts_d;
        end
    end

    // R3: the enable register moves only on an accepted write
    p_en_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(en_q));

    // R6: no unsupported bit ever appears in status
    p_sts_supported_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~SRC_M) == '0);

    // R4: a newly set status bit needs global and per-source enable
    p_latch_gated_r4: assert property (@(posedge clk) disable iff (rst)
        (|(sts_q & ~$past(sts_q))) |->
            ($past(en_q[BIT_GLOBAL_EN]) &&
             ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0)));
endmodule

// File: rtl/irqlc_line.sv
module irqlc_line #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LOC-1:0] raise_vec,
    input  logic [NUM_LOC-1:0] lower_vec,
    output logic               irq
);
    logic irq_d;

    always_comb begin
        irq_d = irq;
        if (|raise_vec)
            irq_d = 1'b1;
        else if (|lower_vec)
            irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_d;
    end

    // R4 / R9: any latch drives the line high next cycle
    p_irq_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (|raise_vec) |=> irq);

    // R7: a clear to zero without a concurrent latch drops the line
    p_irq_lower_r7: assert property (@(posedge clk) disable iff (rst)
        ((|lower_vec) && !(|raise_vec)) |=> !irq);
endmodule

// File: rtl/irqlc_top.sv
module irqlc_top
    import irqlc_pkg::*;
#(
    parameter int         NUM_LOC    = 5,
    parameter bit         WITH_VALID = 1'b1,
    parameter logic [3:0] IRQ_VECTOR = 4'd5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  active_loc,
    input  logic        wr_en,
    input  logic [2:0]  wr_loc,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_loc,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        evt_valid,
    input  logic [2:0]  evt_loc,
    input  logic [7:0]  evt_src,
    output logic        irq
);
    localparam int LOC_W = 3;

    logic               wr_ok;
    logic [31:0]        en_arr  [NUM_LOC];
    logic [31:0]        sts_arr [NUM_LOC];
    logic [NUM_LOC-1:0] raise_vec;
    logic [NUM_LOC-1:0] zero_vec;
    logic [NUM_LOC-1:0] lower_vec;

    assign wr_ok = wr_en && (wr_loc == active_loc) &&
                   (active_loc < LOC_W'(NUM_LOC));

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_slot
        logic sel_me;
        logic sts_we;
        assign sel_me = wr_ok && (wr_loc == LOC_W'(i));
        assign sts_we = sel_me && (wr_sel == SEL_STATUS);

        irqlc_slot #(.WITH_VALID(WITH_VALID)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .en_we     (sel_me && (wr_sel == SEL_ENABLE)),
            .sts_we    (sts_we),
            .wdata     (wr_data),
            .evt_hit   (evt_valid && (evt_loc == LOC_W'(i))),
            .evt_src   (evt_src),
            .en_q      (en_arr[i]),
            .sts_q     (sts_arr[i]),
            .latch_any (raise_vec[i]),
            .zero_next (zero_vec[i])
        );

        assign lower_vec[i] = sts_we && zero_vec[i];
    end

    irqlc_line #(.NUM_LOC(NUM_LOC)) u_line (
        .clk       (clk),
        .rst       (rst),
        .raise_vec (raise_vec),
        .lower_vec (lower_vec),
        .irq       (irq)
    );

    always_comb begin
        rd_data = 32'hFFFF_FFFF;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (rd_loc == LOC_W'(i)) begin
                case (reg_sel_e'(rd_sel))
                    SEL_ENABLE: rd_data = en_arr[i];
                    SEL_STATUS: rd_data = sts_arr[i];
                    SEL_VECTOR: rd_data = {28'b0, IRQ_VECTOR};
                    default:    rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/irqlc_top_test.sv
module irqlc_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  active_loc;
    logic        wr_en;
    logic [2:0]  wr_loc;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [2:0]  rd_loc;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic        evt_valid;
    logic [2:0]  evt_loc;
    logic [7:0]  evt_src;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqlc_top uut (
        .clk(clk), .rst(rst), .active_loc(active_loc),
        .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_valid(evt_valid), .evt_loc(evt_loc), .evt_src(evt_src),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] loc, input logic [1:0] sel, output logic [31:0] v);
        rd_loc = loc; rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] loc, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_loc = loc; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ev(input logic [2:0] loc, input logic [7:0] src);
        @(negedge clk);
        evt_valid = 1'b1; evt_loc = loc; evt_src = src;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), 2'd0, v); chk("R1 enable reset", v, 32'h8);
            rd(3'(i), 2'd2, v); chk("R1 status reset", v, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable_mask();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd2;
        wr(3'd2, 2'd0, 32'hFFFF_FFFF);
        rd(3'd2, 2'd0, v); chk("R2 enable mask", v, 32'h8000_009F);
        wr(3'd2, 2'd0, 32'h0000_0010);
        rd(3'd2, 2'd0, v); chk("R2 polarity only", v, 32'h0000_0010);
    endtask

    task automatic t_nonactive();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd1;
        wr(3'd1, 2'd0, 32'h8000_0087);
        ev(3'd1, 8'h01);
        wr(3'd3, 2'd0, 32'h8000_0087);
        rd(3'd3, 2'd0, v); chk("R3 non-active enable write", v, 32'h8);
        wr(3'd3, 2'd2, 32'hFF);
        active_loc = 3'd7;
        wr(3'd1, 2'd2, 32'h01);
        wr(3'd1, 2'd0, 32'h0);
        rd(3'd1, 2'd2, v); chk("R3 status write with none active", v, 32'h01);
        rd(3'd1, 2'd0, v); chk("R3 enable write with none active", v, 32'h8000_0087);
        chk("R3 irq unchanged", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd0;
        wr(3'd0, 2'd0, 32'h0000_0087);
        ev(3'd0, 8'h87);
        rd(3'd0, 2'd2, v); chk("R4 global enable clear", v, 32'h0);
        chk("R4 no irq without global", {31'b0, irq}, 32'h0);
        wr(3'd0, 2'd0, 32'h8000_0004);
        ev(3'd0, 8'h83);
        rd(3'd0, 2'd2, v); chk("R4 source not enabled", v, 32'h0);
        chk("R4 no irq source off", {31'b0, irq}, 32'h0);
        ev(3'd0, 8'h86);
        rd(3'd0, 2'd2, v); chk("R4 enabled source latches", v, 32'h04);
        chk("R4 irq raised", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_invalid_loc();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            active_loc = 3'(i);
            wr(3'(i), 2'd0, 32'h8000_0087);
        end
        ev(3'd5, 8'h87);
        ev(3'd7, 8'h87);
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), 2'd2, v); chk("R5 invalid event discarded", v, 32'h0);
        end
        chk("R5 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_w1c_lower();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd1;
        wr(3'd1, 2'd0, 32'h8000_0087);
        ev(3'd1, 8'h81);
        wr(3'd1, 2'd2, 32'hFFFF_FF7E);
        rd(3'd1, 2'd2, v); chk("R6 unsupported and zero bits no effect", v, 32'h81);
        wr(3'd1, 2'd2, 32'h01);
        rd(3'd1, 2'd2, v); chk("R6 w1c one bit", v, 32'h80);
        chk("R7 irq stays while nonzero", {31'b0, irq}, 32'h1);
        wr(3'd1, 2'd2, 32'h80);
        rd(3'd1, 2'd2, v); chk("R6 w1c last bit", v, 32'h0);
        chk("R7 irq lowered", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_lower_other_pending();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd2;
        wr(3'd2, 2'd0, 32'h8000_0080);
        ev(3'd2, 8'h80);
        active_loc = 3'd1;
        wr(3'd1, 2'd0, 32'h8000_0001);
        ev(3'd1, 8'h01);
        wr(3'd1, 2'd2, 32'h01);
        chk("R7 irq drops with other locality pending", {31'b0, irq}, 32'h0);
        rd(3'd2, 2'd2, v); chk("R7 other locality keeps bit", v, 32'h80);
    endtask

    task automatic t_vector();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd0;
        wr(3'd0, 2'd1, 32'hFFFF_FFFF);
        rd(3'd0, 2'd1, v); chk("R8 vector fixed", v, 32'h5);
        rd(3'd4, 2'd1, v); chk("R8 vector other locality", v, 32'h5);
        rd(3'd6, 2'd0, v); chk("R8 invalid locality read", v, 32'hFFFF_FFFF);
        rd(3'd0, 2'd3, v); chk("R8 spare select", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd4;
        wr(3'd4, 2'd0, 32'h8000_0002);
        ev(3'd4, 8'h02);
        @(negedge clk);
        wr_en = 1'b1; wr_loc = 3'd4; wr_sel = 2'd2; wr_data = 32'h02;
        evt_valid = 1'b1; evt_loc = 3'd4; evt_src = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
        rd(3'd4, 2'd2, v); chk("R9 event beats clear", v, 32'h02);
        chk("R9 irq high", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        do_reset();
        active_loc = 3'd3;
        wr(3'd3, 2'd0, 32'h8000_0018);
        rd(3'd3, 2'd0, v); chk("R10 polarity readback", v, 32'h8000_0018);
        chk("R10 irq not inverted", {31'b0, irq}, 32'h0);
        wr(3'd3, 2'd0, 32'h8000_0019);
        ev(3'd3, 8'h01);
        chk("R10 irq active-high", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        rst = 1'b1; active_loc = 3'd7;
        wr_en = 1'b0; wr_loc = '0; wr_sel = '0; wr_data = '0;
        rd_loc = '0; rd_sel = '0;
        evt_valid = 1'b0; evt_loc = '0; evt_src = '0;
        t_reset();
        t_enable_mask();
        t_nonactive();
        t_gating();
        t_invalid_loc();
        t_w1c_lower();
        t_lower_other_pending();
        t_vector();
        t_collide();
        t_polarity();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule